// File: doc/BRIEF.md
# Flash programming controller front end

This block connects a 32-bit memory-mapped bus to an embedded flash array and turns ordinary bus stores into array operations. Software writes an action code into a small register file to select a continuous operating mode. Stores that land in the flash address window then start work without any explicit command. In block-write mode four collected words are programmed as one block. In page-erase mode a single store blanks the whole page that contains its address. In blank-verify mode four collected words are compared against the stored contents.

A status register reports a busy flag, a verify-failure field and a sticky protection fault. A configuration register holds a hard-read level and the number of protected sectors, counted upward from sector 0. The chosen mode stays active across any number of blocks or pages until software writes the idle code back.

The array itself is a behavioural model. Its cells reset to the erased state, a program can only clear bits, and each kind of operation takes a fixed, parameterised number of cycles.

Top module: `flc_top`

## Requirements
- R1: Address bit 11 set selects the register region, and byte offsets 0x0, 0x4 and 0x8 in it hold status, program-action and configuration; any other offset reads 0. After reset all three read 0 and every array word reads 0xFFFFFFFF.
- R2: Action bits [1:0] give the operation type (1 write, 2 page erase, 0 verify) and bits [5:4] give the selector, where 2 means continuous. Any code whose selector is not 2, or whose type is 3, is idle, and in idle a store to the flash window changes nothing.
- R3: In write mode, stores to the four word offsets of a block (byte offsets 0x0, 0x4, 0x8, 0xC) start one program after the fourth store. Each programmed array word becomes its old value AND the stored word.
- R4: Status bit 0 reads 1 starting with the cycle after the launching store, for T_PROG, T_ERASE or T_VERIFY cycles (defaults 8, 20, 4). The array change is readable in the first cycle that status bit 0 reads 0.
- R5: While status bit 0 is set, a store to the flash window drives bus_wait high and has no effect. Register accesses and window reads are never stalled.
- R6: In page-erase mode, one store of any value to any address inside a 64-word page sets every word of that page to 0xFFFFFFFF and leaves all other pages unchanged.
- R7: In verify mode, four stores to a block are compared with the array. Any mismatch sets status bits [3:2] to 01; a full match leaves them at 00. Verify never changes the array.
- R8: The mode stays in force across successive blocks and pages until the action register is rewritten.
- R9: Any write to the action register throws away a partly collected block. The next four stores then form a fresh block.
- R10: Configuration bits [11:4] hold a protected-sector count, with a sector being 128 words. A write-mode or erase-mode store into a sector whose index is below that count is dropped and sets status bit 4. Verify-mode stores are not blocked.
- R11: Status bits [3:2] and bit 4 stay set until the action register is written, which clears both.
- R12: The configuration register keeps only bits [2:1] (hard-read level) and [11:4]; all other bits read 0.
- R13: A read of the flash window returns the addressed array word in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus access request this cycle |
| bus_write | input | 1 | 1 = store, 0 = load |
| bus_addr | input | 12 | Byte address; bit 11 selects the register region |
| bus_wdata | input | 32 | Store data |
| bus_rdata | output | 32 | Load data, combinational |
| bus_wait | output | 1 | Window store stalled by a running operation |

## Verification
Read data and bus_wait are combinational, so the bench compares them in the same cycle it drives the access, one nanosecond after the inputs change. A launching store is taken at a clock edge. Status bit 0 must then read 1 from the next cycle, for exactly the operation latency, and the new array contents must appear in the first cycle it reads 0. While an operation runs, the bench reads status on every cycle, so both edges of the busy window are checked at the exact cycle. A cycle-level reference model in the bench steps its busy countdown, its collection buffer and its array copy on the same edges, and its predictions are compared with the ports on every cycle.

// File: rtl/flc_pkg.sv
`timescale 1ns/1ps
package flc_pkg;

    // Array operation selected by the current action code
    typedef enum logic [1:0] {
        OP_IDLE   = 2'd0,
        OP_PROG   = 2'd1,
        OP_ERASE  = 2'd2,
        OP_VERIFY = 2'd3
    } op_e;

    // Register offsets inside the register region (these map software fields)
    localparam logic [3:0] OFS_STATUS = 4'h0;
    localparam logic [3:0] OFS_ACTION = 4'h4;
    localparam logic [3:0] OFS_CONFIG = 4'h8;

    // Configuration bits that are kept: hard-read level [2:1], protect count [11:4]
    localparam logic [15:0] CONF_KEEP = 16'h0FF6;
    localparam logic [1:0]  SEL_CONTINUOUS = 2'd2;
    localparam logic [1:0]  VERR_MISMATCH  = 2'b01;

    typedef struct packed {
        logic [1:0] verify_sel;
        logic [1:0] shot_sel;
        logic [1:0] spare;
        logic [1:0] optype;
    } action_t;

    typedef struct packed {
        logic [10:0] zero;
        logic        prot_err;
        logic [1:0]  verr;
        logic        gap;
        logic        busy;
    } status_t;

    function automatic op_e decode_action(action_t a);
        op_e r;
        r = OP_IDLE;
        if (a.shot_sel == SEL_CONTINUOUS) begin
            case (a.optype)
                2'd1:    r = OP_PROG;
                2'd2:    r = OP_ERASE;
                2'd0:    r = OP_VERIFY;
                default: r = OP_IDLE;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/flc_collect.sv
`timescale 1ns/1ps
module flc_collect #(
    parameter int BLOCK_WORDS = 4,
    parameter int WORD_W      = 32
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            clear,
    input  logic                            store,
    input  logic [$clog2(BLOCK_WORDS)-1:0]  idx,
    input  logic [WORD_W-1:0]               wdata,
    output logic                            last,
    output logic [BLOCK_WORDS*WORD_W-1:0]   blk_data
);
    localparam int CNT_W = $clog2(BLOCK_WORDS);

    logic [CNT_W-1:0]  cnt_q;
    logic [WORD_W-1:0] buf_q [BLOCK_WORDS];

    assign last = store && (cnt_q == CNT_W'(BLOCK_WORDS - 1));

    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt_q <= '0;
        else if (store)
            cnt_q <= last ? '0 : cnt_q + CNT_W'(1);
    end

    for (genvar g = 0; g < BLOCK_WORDS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                buf_q[g] <= '1;
            else if (store && idx == CNT_W'(g))
                buf_q[g] <= wdata;
        end
        // the word arriving with the last store is merged in directly
        assign blk_data[g*WORD_W +: WORD_W] =
            (store && idx == CNT_W'(g)) ? wdata : buf_q[g];
    end

    // R9: a clear leaves no words pending
    p_clear_empties_r9: assert property (@(posedge clk) disable iff (rst)
        clear |=> (cnt_q == '0));

endmodule

// File: rtl/flc_seq.sv
`timescale 1ns/1ps
module flc_seq
    import flc_pkg::*;
#(
    parameter int BLOCK_BITS = 128,
    parameter int WA_W       = 9,
    parameter int T_PROG     = 8,
    parameter int T_ERASE    = 20,
    parameter int T_VERIFY   = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  launch,
    input  op_e                   launch_op,
    input  logic [WA_W-1:0]       launch_addr,
    input  logic [BLOCK_BITS-1:0] launch_data,
    input  logic [BLOCK_BITS-1:0] rd_blk,
    output logic                  busy,
    output logic [WA_W-1:0]       op_addr,
    output logic [BLOCK_BITS-1:0] op_data,
    output logic                  commit_prog,
    output logic                  commit_erase,
    output logic                  verify_fail
);
    localparam int T_PE  = (T_PROG > T_ERASE) ? T_PROG : T_ERASE;
    localparam int T_MAX = (T_PE > T_VERIFY) ? T_PE : T_VERIFY;
    localparam int TW    = $clog2(T_MAX + 1);

    logic [TW-1:0] tmr_q;
    logic [TW-1:0] lat;
    op_e           op_q;
    logic          finish;

    always_comb begin
        case (launch_op)
            OP_PROG:  lat = TW'(T_PROG);
            OP_ERASE: lat = TW'(T_ERASE);
            default:  lat = TW'(T_VERIFY);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            tmr_q   <= '0;
            op_q    <= OP_IDLE;
            op_addr <= '0;
            op_data <= '0;
        end else if (launch) begin
            busy    <= 1'b1;
            tmr_q   <= lat;
            op_q    <= launch_op;
            op_addr <= launch_addr;
            op_data <= launch_data;
        end else if (busy) begin
            tmr_q <= tmr_q - TW'(1);
            if (tmr_q == TW'(1))
                busy <= 1'b0;
        end
    end

    assign finish       = busy && (tmr_q == TW'(1));
    assign commit_prog  = finish && (op_q == OP_PROG);
    assign commit_erase = finish && (op_q == OP_ERASE);
    assign verify_fail  = finish && (op_q == OP_VERIFY) && (rd_blk != op_data);

    // R5: no operation is launched over a running one
    p_launch_when_free_r5: assert property (@(posedge clk) disable iff (rst)
        launch |-> !busy);
    // R4: busy follows a launch on the next cycle
    p_busy_after_launch_r4: assert property (@(posedge clk) disable iff (rst)
        launch |=> busy);

endmodule

// File: rtl/flc_array.sv
`timescale 1ns/1ps
module flc_array #(
    parameter int NUM_WORDS   = 512,
    parameter int PAGE_WORDS  = 64,
    parameter int BLOCK_WORDS = 4,
    parameter int WORD_W      = 32
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            prog_en,
    input  logic                            erase_en,
    input  logic [$clog2(NUM_WORDS)-1:0]    op_addr,
    input  logic [BLOCK_WORDS*WORD_W-1:0]   prog_data,
    output logic [BLOCK_WORDS*WORD_W-1:0]   blk_rdata,
    input  logic [$clog2(NUM_WORDS)-1:0]    rd_addr,
    output logic [WORD_W-1:0]               rd_data
);
    localparam int WA_W = $clog2(NUM_WORDS);

    logic [WORD_W-1:0] mem_q [NUM_WORDS];
    logic [WA_W-1:0]   blk_base;
    logic [WA_W-1:0]   pg_base;

    assign blk_base = op_addr & ~WA_W'(BLOCK_WORDS - 1);
    assign pg_base  = op_addr & ~WA_W'(PAGE_WORDS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_WORDS; i++)
                mem_q[i] <= '1;
        end else if (prog_en) begin
            for (int b = 0; b < BLOCK_WORDS; b++)
                mem_q[blk_base + WA_W'(b)] <= mem_q[blk_base + WA_W'(b)]
                                              & prog_data[b*WORD_W +: WORD_W];
        end else if (erase_en) begin
            for (int p = 0; p < PAGE_WORDS; p++)
                mem_q[pg_base + WA_W'(p)] <= '1;
        end
    end

    for (genvar g = 0; g < BLOCK_WORDS; g++) begin : g_rd
        assign blk_rdata[g*WORD_W +: WORD_W] = mem_q[blk_base + WA_W'(g)];
    end

    assign rd_data = mem_q[rd_addr];

    // R6: first and last word of an erased page are blank afterwards
    p_erase_blank_r6: assert property (@(posedge clk) disable iff (rst)
        erase_en |=> (mem_q[$past(pg_base)] == '1)
                  && (mem_q[$past(pg_base) + WA_W'(PAGE_WORDS - 1)] == '1));

endmodule

// File: rtl/flc_top.sv
`timescale 1ns/1ps
module flc_top
    import flc_pkg::*;
#(
    parameter int NUM_SECTORS  = 4,
    parameter int SECTOR_PAGES = 2,
    parameter int PAGE_BLOCKS  = 16,
    parameter int BLOCK_WORDS  = 4,
    parameter int T_PROG       = 8,
    parameter int T_ERASE      = 20,
    parameter int T_VERIFY     = 4,
    localparam int ADDR_W = $clog2(NUM_SECTORS * SECTOR_PAGES * PAGE_BLOCKS * BLOCK_WORDS) + 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_wait
);
    localparam int WORD_W       = 32;
    localparam int PAGE_WORDS   = PAGE_BLOCKS * BLOCK_WORDS;
    localparam int SECTOR_WORDS = PAGE_WORDS * SECTOR_PAGES;
    localparam int NUM_WORDS    = SECTOR_WORDS * NUM_SECTORS;
    localparam int WA_W         = $clog2(NUM_WORDS);
    localparam int BLK_W        = $clog2(BLOCK_WORDS);
    localparam int SECT_SH      = $clog2(SECTOR_WORDS);
    localparam int BLOCK_BITS   = BLOCK_WORDS * WORD_W;

    // register state
    action_t     act_q;
    logic [15:0] conf_q;
    logic [1:0]  verr_q;
    logic        perr_q;

    // bus decode
    logic            reg_sel, win_store, act_wr, conf_wr;
    logic [WA_W-1:0] waddr;
    logic [3:0]      roff;
    op_e             mode;
    logic [7:0]      sec_idx, prot_cnt;
    logic            guarded, prot_hit, collect_store, erase_launch;

    // datapath between submodules
    logic                  busy, blk_last, launch;
    op_e                   launch_op;
    logic [BLOCK_BITS-1:0] blk_data, op_data, rd_blk;
    logic [WA_W-1:0]       op_addr;
    logic                  commit_prog, commit_erase, verify_fail;
    logic [WORD_W-1:0]     arr_rdata;
    status_t               stat;

    assign reg_sel   = bus_addr[ADDR_W-1];
    assign waddr     = bus_addr[WA_W+1:2];
    assign roff      = bus_addr[3:0];
    assign bus_wait  = bus_valid && bus_write && !reg_sel && busy;
    assign win_store = bus_valid && bus_write && !reg_sel && !busy;
    assign act_wr    = bus_valid && bus_write && reg_sel && (roff == OFS_ACTION);
    assign conf_wr   = bus_valid && bus_write && reg_sel && (roff == OFS_CONFIG);

    assign mode     = decode_action(act_q);
    assign sec_idx  = 8'(waddr >> SECT_SH);
    assign prot_cnt = conf_q[11:4];
    assign guarded  = ((mode == OP_PROG) || (mode == OP_ERASE)) && (sec_idx < prot_cnt);

    assign prot_hit      = win_store && guarded;
    assign collect_store = win_store && !guarded && ((mode == OP_PROG) || (mode == OP_VERIFY));
    assign erase_launch  = win_store && !guarded && (mode == OP_ERASE);
    assign launch        = blk_last || erase_launch;
    assign launch_op     = erase_launch ? OP_ERASE : mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q  <= '0;
            conf_q <= '0;
            verr_q <= '0;
            perr_q <= 1'b0;
        end else begin
            if (act_wr) begin
                act_q  <= action_t'(bus_wdata[7:0]);
                verr_q <= '0;
                perr_q <= 1'b0;
            end
            if (conf_wr)
                conf_q <= bus_wdata[15:0] & CONF_KEEP;
            if (prot_hit)
                perr_q <= 1'b1;
            if (verify_fail)
                verr_q <= VERR_MISMATCH;
        end
    end

    flc_collect #(
        .BLOCK_WORDS(BLOCK_WORDS),
        .WORD_W     (WORD_W)
    ) u_collect (
        .clk     (clk),
        .rst     (rst),
        .clear   (act_wr),
        .store   (collect_store),
        .idx     (waddr[BLK_W-1:0]),
        .wdata   (bus_wdata),
        .last    (blk_last),
        .blk_data(blk_data)
    );

    flc_seq #(
        .BLOCK_BITS(BLOCK_BITS),
        .WA_W      (WA_W),
        .T_PROG    (T_PROG),
        .T_ERASE   (T_ERASE),
        .T_VERIFY  (T_VERIFY)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .launch      (launch),
        .launch_op   (launch_op),
        .launch_addr (waddr),
        .launch_data (blk_data),
        .rd_blk      (rd_blk),
        .busy        (busy),
        .op_addr     (op_addr),
        .op_data     (op_data),
        .commit_prog (commit_prog),
        .commit_erase(commit_erase),
        .verify_fail (verify_fail)
    );

    flc_array #(
        .NUM_WORDS  (NUM_WORDS),
        .PAGE_WORDS (PAGE_WORDS),
        .BLOCK_WORDS(BLOCK_WORDS),
        .WORD_W     (WORD_W)
    ) u_array (
        .clk      (clk),
        .rst      (rst),
        .prog_en  (commit_prog),
        .erase_en (commit_erase),
        .op_addr  (op_addr),
        .prog_data(op_data),
        .blk_rdata(rd_blk),
        .rd_addr  (waddr),
        .rd_data  (arr_rdata)
    );

    always_comb begin
        stat          = '0;
        stat.busy     = busy;
        stat.verr     = verr_q;
        stat.prot_err = perr_q;
        bus_rdata     = '0;
        if (reg_sel) begin
            case (roff)
                OFS_STATUS: bus_rdata = {16'h0, stat};
                OFS_ACTION: bus_rdata = {24'h0, act_q};
                OFS_CONFIG: bus_rdata = {16'h0, conf_q};
                default:    bus_rdata = '0;
            endcase
        end else begin
            bus_rdata = arr_rdata;
        end
    end

    // R11: the protection fault holds until the action register is written
    p_perr_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        (perr_q && !act_wr) |=> perr_q);
    // R2: an idle code never starts an operation
    p_idle_no_launch_r2: assert property (@(posedge clk) disable iff (rst)
        (mode == OP_IDLE) |-> !launch);
    // R10: a guarded store never starts an operation
    p_guard_blocks_r10: assert property (@(posedge clk) disable iff (rst)
        prot_hit |-> !launch);

endmodule

// File: tb/tb_flc_top.sv
`timescale 1ns/1ps
module tb_flc_top;

    localparam int T_PROG   = 8;
    localparam int T_ERASE  = 20;
    localparam int T_VERIFY = 4;
    localparam logic [11:0] A_STAT = 12'h800;
    localparam logic [11:0] A_ACT  = 12'h804;
    localparam logic [11:0] A_CONF = 12'h808;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_wait;

    always #5 clk = ~clk;

    flc_top dut (
        .clk      (clk),
        .rst      (rst),
        .bus_valid(bus_valid),
        .bus_write(bus_write),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .bus_wait (bus_wait)
    );

    // reference model state
    logic [31:0] m_mem [512];
    logic [7:0]  m_act;
    logic [15:0] m_conf;
    logic [1:0]  m_verr;
    logic        m_perr;
    int          m_busy;
    int          m_cnt;
    logic [31:0] m_buf [4];
    int          p_op;
    int          p_base;
    logic [31:0] p_data [4];

    int    vectors = 0;
    int    misses  = 0;
    bit    done    = 0;
    string cur_req = "R1";

    function automatic int m_mode();
        int shot, typ;
        shot = (m_act >> 4) & 3;
        typ  = m_act & 3;
        if (shot != 2) return 0;
        if (typ == 1) return 1;
        if (typ == 2) return 2;
        if (typ == 0) return 3;
        return 0;
    endfunction

    function automatic logic [31:0] m_read(logic [11:0] a);
        if (a[11]) begin
            case (a[3:0])
                4'h0: return {27'h0, m_perr, m_verr, 1'b0, (m_busy > 0)};
                4'h4: return {24'h0, m_act};
                4'h8: return {16'h0, m_conf};
                default: return 32'h0;
            endcase
        end
        return m_mem[a[10:2]];
    endfunction

    task automatic m_commit();
        if (p_op == 1) begin
            for (int i = 0; i < 4; i++) m_mem[p_base + i] = m_mem[p_base + i] & p_data[i];
        end else if (p_op == 2) begin
            for (int i = 0; i < 64; i++) m_mem[p_base + i] = 32'hFFFF_FFFF;
        end else if (p_op == 3) begin
            for (int i = 0; i < 4; i++) if (m_mem[p_base + i] != p_data[i]) m_verr = 2'b01;
        end
    endtask

    task automatic m_reset();
        for (int i = 0; i < 512; i++) m_mem[i] = 32'hFFFF_FFFF;
        m_act = 0; m_conf = 0; m_verr = 0; m_perr = 0; m_busy = 0; m_cnt = 0; p_op = 0; p_base = 0;
    endtask

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    // one bus cycle: drive, compare combinational outputs, step model at the edge
    task automatic cyc(bit v, bit w, logic [11:0] a, logic [31:0] d);
        bit busy_pre;
        int wi, mode, sec;
        bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = d;
        #1;
        busy_pre = (m_busy > 0);
        chk("bus_wait", {31'h0, bus_wait}, {31'h0, v && w && !a[11] && busy_pre});
        if (v && !w) chk("rdata", bus_rdata, m_read(a));
        @(posedge clk);
        if (m_busy > 0) begin
            m_busy--;
            if (m_busy == 0) m_commit();
        end
        if (v && w && a[11]) begin
            if (a[3:0] == 4'h4) begin m_act = d[7:0]; m_cnt = 0; m_verr = 0; m_perr = 0; end
            if (a[3:0] == 4'h8) m_conf = d[15:0] & 16'h0FF6;
        end else if (v && w && !busy_pre) begin
            wi = int'(a[10:2]);
            mode = m_mode();
            sec = wi / 128;
            if ((mode == 1 || mode == 2) && sec < int'(m_conf[11:4])) m_perr = 1;
            else if (mode == 1 || mode == 3) begin
                m_buf[wi % 4] = d;
                m_cnt++;
                if (m_cnt == 4) begin
                    m_cnt = 0; p_op = mode; p_base = wi - wi % 4;
                    for (int i = 0; i < 4; i++) p_data[i] = m_buf[i];
                    m_busy = (mode == 1) ? T_PROG : T_VERIFY;
                end
            end else if (mode == 2) begin
                p_op = 2; p_base = wi - wi % 64; m_busy = T_ERASE;
            end
        end
        @(negedge clk);
    endtask

    task automatic rd(logic [11:0] a); cyc(1, 0, a, 32'h0); endtask
    task automatic wr(logic [11:0] a, logic [31:0] d); cyc(1, 1, a, d); endtask
    task automatic settle(); while (m_busy > 0) rd(A_STAT); rd(A_STAT); endtask
    task automatic store_block(logic [11:0] base, logic [31:0] w0, logic [31:0] w1,
                               logic [31:0] w2, logic [31:0] w3);
        wr(base, w0); wr(base + 12'h4, w1); wr(base + 12'h8, w2); wr(base + 12'hC, w3);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            misses++; vectors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        m_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state and register map; R13 window reads
        cur_req = "R1";
        rd(A_STAT); rd(A_ACT); rd(A_CONF); rd(12'h80C);
        cur_req = "R13";
        rd(12'h000); rd(12'h7FC); rd(12'h200);

        // R2 idle and non-continuous codes ignore window stores
        cur_req = "R2";
        wr(12'h200, 32'h0); rd(12'h200); rd(A_STAT);
        wr(A_ACT, 32'h91); wr(12'h200, 32'h0); wr(12'h204, 32'h0);
        wr(12'h208, 32'h0); wr(12'h20C, 32'h0); rd(A_STAT); rd(12'h200);
        wr(A_ACT, 32'hA3); wr(12'h200, 32'h0); rd(A_STAT); rd(12'h200);

        // R3 block write, R4 busy window, R5 stall
        cur_req = "R3";
        wr(A_ACT, 32'hA1); rd(A_ACT);
        store_block(12'h200, 32'h1234_5678, 32'hDEAD_BEEF, 32'h0F0F_0F0F, 32'hA5A5_A5A5);
        cur_req = "R5";
        wr(12'h300, 32'h0); rd(12'h200); rd(A_CONF);
        cur_req = "R4";
        settle();
        cur_req = "R3";
        rd(12'h200); rd(12'h204); rd(12'h208); rd(12'h20C);
        // R8 mode persists to a second block; AND behaviour on reprogram
        cur_req = "R8";
        store_block(12'h210, 32'h1111_1111, 32'h2222_2222, 32'h3333_3333, 32'h4444_4444);
        settle(); rd(12'h210); rd(12'h21C);
        cur_req = "R3";
        store_block(12'h200, 32'hFFFF_0000, 32'hFFFF_FFFF, 32'h00FF_FF00, 32'hFFFF_FFFF);
        settle(); rd(12'h200); rd(12'h208);

        // R9 partial block discarded on action write
        cur_req = "R9";
        wr(12'h240, 32'h0000_0001); wr(12'h244, 32'h0000_0002);
        wr(A_ACT, 32'hA1);
        wr(12'h248, 32'h0000_0003); wr(12'h24C, 32'h0000_0004);
        rd(A_STAT); rd(12'h248);
        wr(12'h240, 32'h0000_0005); wr(12'h244, 32'h0000_0006);
        settle(); rd(12'h240); rd(12'h244); rd(12'h248); rd(12'h24C);

        // R6 page erase, R8 across pages
        cur_req = "R6";
        wr(A_ACT, 32'hA2);
        wr(12'h2A8, 32'h0);
        cur_req = "R5";
        wr(12'h400, 32'h0);
        cur_req = "R4";
        settle();
        cur_req = "R6";
        rd(12'h200); rd(12'h210); rd(12'h24C); rd(12'h2FC);
        cur_req = "R8";
        wr(A_ACT, 32'hA1);
        store_block(12'h300, 32'h0, 32'h0, 32'h0, 32'h0);
        settle();
        wr(A_ACT, 32'hA2);
        wr(12'h3F0, 32'h5);
        settle(); rd(12'h300); rd(12'h3FC);
        wr(12'h500, 32'h5); settle(); rd(12'h500);

        // R7 verify
        cur_req = "R7";
        wr(A_ACT, 32'hA1);
        store_block(12'h600, 32'hCAFE_0001, 32'hCAFE_0002, 32'hCAFE_0003, 32'hCAFE_0004);
        settle();
        wr(A_ACT, 32'hE0);
        store_block(12'h600, 32'hCAFE_0001, 32'hCAFE_0002, 32'hCAFE_0003, 32'hCAFE_0004);
        settle(); rd(A_STAT);
        store_block(12'h600, 32'hCAFE_0001, 32'hCAFE_0002, 32'hCAFE_0013, 32'hCAFE_0004);
        settle(); rd(A_STAT); rd(12'h608);
        // R11 sticky until action write
        cur_req = "R11";
        store_block(12'h600, 32'hCAFE_0001, 32'hCAFE_0002, 32'hCAFE_0003, 32'hCAFE_0004);
        settle(); rd(A_STAT);
        wr(A_ACT, 32'hE0); rd(A_STAT);

        // R12 configuration masking
        cur_req = "R12";
        wr(A_CONF, 32'hFFFF_F01D); rd(A_CONF);

        // R10 protection of sector 0
        cur_req = "R10";
        wr(A_ACT, 32'hA1);
        store_block(12'h040, 32'h0, 32'h0, 32'h0, 32'h0);
        rd(A_STAT); rd(12'h040);
        store_block(12'h240, 32'h0, 32'h0, 32'h0, 32'h0);
        settle(); rd(12'h240); rd(A_STAT);
        cur_req = "R11";
        wr(A_ACT, 32'hA2); rd(A_STAT);
        cur_req = "R10";
        wr(12'h010, 32'h0); rd(A_STAT); rd(12'h010);
        wr(A_ACT, 32'hE0);
        store_block(12'h040, 32'h0, 32'h0, 32'h0, 32'h0);
        settle(); rd(A_STAT);

        cyc(0, 0, 12'h0, 32'h0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule